// File: doc/BRIEF.md
# Reset Supervisor with Bus-Activity Watchdog

This block produces the system reset for a board-level controller from two independent causes. The first is a flag from an analog comparator that reports the supply rail below its trip level. The second is a watchdog that expects the serial data line of a two-wire bus to change level now and then. Host activity on the bus services the watchdog, so the host needs no dedicated kick pin. A line that stays high or stays low for longer than the selected window is taken to mean a hung host.

Every reset cause loads one shared hold counter. Reset therefore stays asserted for a full hold window after the supply has been good continuously, and equally after a watchdog expiry. The hold window is nominally a quarter of a second and is given as a cycle count. The output pin is modelled as open-drain. An enable says when the pin is pulled, and a level says which level it is pulled to. The pin is only driven while reset is active. A small status field records which source caused the most recent reset, and a write strobe clears it.

Top module: `rst_supervisor`

## Requirements
- R1: While `por_n` is low, `rst_oe` is 1 and `rst_cause` is 01. After `por_n` rises with the supply flag low, `rst_oe` stays 1 through rising edge HOLD_CYCLES+1 and reads 0 from rising edge HOLD_CYCLES+2, counting edges after the release.
- R2: When `supply_low_a` rises, `rst_oe` is still 0 after the second rising edge and 1 from the third rising edge. It stays 1 for as long as the flag stays high.
- R3: When `supply_low_a` falls, `rst_oe` stays 1 through rising edge HOLD_CYCLES+1 and reads 0 from rising edge HOLD_CYCLES+2.
- R4: With `wd_en`=1 and `wd_sel` set to 1, 2 or 3, the window is WD_T1, WD_T2 or WD_T3 cycles. If `sda_in` does not change after a transition, `rst_oe` is 0 after rising edge W+2 and 1 from rising edge W+3, where W is the selected window.
- R5: Transitions of `sda_in` in either direction, spaced closer than the window, keep `rst_oe` at 0.
- R6: With `wd_en`=0, or with `wd_sel`=0, a static `sda_in` never asserts reset.
- R7: A watchdog expiry holds reset for HOLD_CYCLES cycles. `rst_oe` is 1 on edge E+HOLD_CYCLES-1 and 0 on edge E+HOLD_CYCLES, where E is the edge that asserted reset.
- R8: `rst_lvl` follows `rst_pol_high` (1 means active-high), and `rst_oe` is 1 only while reset is active.
- R9: `rst_cause` is 01 for the supply, 10 for the watchdog and 00 for none. It is set when a cause is present and cleared by `status_clr` on the next edge. A cause present on the same edge wins over the clear.
- R10: The watchdog count is held at zero while reset is active. With a static line after a watchdog release on edge E+HOLD_CYCLES, the next expiry comes exactly W cycles later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| supply_low_a | input | 1 | Asynchronous comparator flag: supply below trip |
| sda_in | input | 1 | Sampled serial data line |
| wd_en | input | 1 | Watchdog enable |
| wd_sel | input | 2 | Window select: 0 off, 1..3 increasing windows |
| rst_pol_high | input | 1 | 1 = reset active high, 0 = active low |
| status_clr | input | 1 | Write strobe that clears the cause status |
| rst_oe | output | 1 | Open-drain pull enable, 1 while reset is active |
| rst_lvl | output | 1 | Level that the pin is pulled to when enabled |
| rst_cause | output | 2 | Cause of the last reset: 00 none, 01 supply, 10 watchdog |

## Verification
The hardest situation to reach is a second watchdog expiry that comes straight after the hold window of the first. It shows that the count was frozen during reset and restarts from zero on the release edge, and it can only be told apart from a drifting count by its exact cycle. The stimulus lets the line go quiet on a known edge and predicts the expiry edge, the release edge and the next expiry edge from the window and hold counts. Each of these is queued against a free-running cycle count. The clear-versus-cause race is reached the same way: the status strobe is placed on the edge where the synchronised supply flag first becomes visible.

// File: rtl/rsv_pkg.sv
package rsv_pkg;
    typedef enum logic [1:0] {
        CAUSE_NONE   = 2'b00,
        CAUSE_SUPPLY = 2'b01,
        CAUSE_WDOG   = 2'b10
    } cause_e;
endpackage

// File: rtl/rsv_sync2.sv
module rsv_sync2 #(
    parameter int unsigned       W       = 1,
    parameter logic [W-1:0]      RST_VAL = '0
) (
    input  logic         clk,
    input  logic         por_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] meta_d, meta_q, out_d, out_q;

    always_comb begin
        meta_d = din;
        out_d  = meta_q;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            meta_q <= RST_VAL;
            out_q  <= RST_VAL;
        end else begin
            meta_q <= meta_d;
            out_q  <= out_d;
        end
    end

    assign dout = out_q;
endmodule

// File: rtl/rsv_bus_watchdog.sv
module rsv_bus_watchdog #(
    parameter int unsigned WD_T1 = 100_000,
    parameter int unsigned WD_T2 = 600_000,
    parameter int unsigned WD_T3 = 1_400_000
) (
    input  logic       clk,
    input  logic       por_n,
    input  logic       sda_s,
    input  logic       arm,
    input  logic [1:0] sel,
    output logic       expire
);
    localparam int unsigned T_MAX12 = (WD_T1 > WD_T2) ? WD_T1 : WD_T2;
    localparam int unsigned T_MAX   = (T_MAX12 > WD_T3) ? T_MAX12 : WD_T3;
    localparam int unsigned CNT_W   = $clog2(T_MAX + 1);

    typedef struct packed {
        logic             prev;
        logic [CNT_W-1:0] cnt;
    } wd_state_t;

    wd_state_t        st_d, st_q;
    logic [CNT_W-1:0] limit;
    logic             line_edge;
    logic             expire_c;

    always_comb begin
        unique case (sel)
            2'd2:    limit = CNT_W'(WD_T2);
            2'd3:    limit = CNT_W'(WD_T3);
            default: limit = CNT_W'(WD_T1);
        endcase
    end

    always_comb begin
        st_d      = st_q;
        expire_c  = 1'b0;
        line_edge = sda_s ^ st_q.prev;
        st_d.prev = sda_s;
        if (!arm || line_edge) begin
            st_d.cnt = '0;
        end else if (st_q.cnt == limit - CNT_W'(1)) begin
            st_d.cnt = '0;
            expire_c = 1'b1;
        end else begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign expire = expire_c;

    // R5: a line transition restarts the quiet-time count
    assert_edge_restarts_R5: assert property (@(posedge clk) disable iff (!por_n)
        (arm && line_edge) |=> (st_q.cnt == '0));

    // R6: a disarmed watchdog keeps its count at zero and never expires
    assert_idle_when_off_R6: assert property (@(posedge clk) disable iff (!por_n)
        !arm |-> !expire);

    // R4: the count never reaches the largest window
    assert_count_bound_R4: assert property (@(posedge clk) disable iff (!por_n)
        st_q.cnt < CNT_W'(T_MAX));
endmodule

// File: rtl/rsv_hold_ctrl.sv
module rsv_hold_ctrl
    import rsv_pkg::*;
#(
    parameter int unsigned HOLD_CYCLES = 250_000
) (
    input  logic       clk,
    input  logic       por_n,
    input  logic       sup_low,
    input  logic       wd_exp,
    input  logic       status_clr,
    output logic       rst_active,
    output logic [1:0] cause
);
    localparam int unsigned HOLD_W = $clog2(HOLD_CYCLES + 1);

    typedef struct packed {
        logic              rst;
        logic [HOLD_W-1:0] hold;
        cause_e            cause;
    } hc_state_t;

    hc_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (sup_low) begin
            st_d.rst   = 1'b1;
            st_d.hold  = HOLD_W'(HOLD_CYCLES);
            st_d.cause = CAUSE_SUPPLY;
        end else if (wd_exp) begin
            st_d.rst   = 1'b1;
            st_d.hold  = HOLD_W'(HOLD_CYCLES);
            st_d.cause = CAUSE_WDOG;
        end else begin
            if (status_clr) begin
                st_d.cause = CAUSE_NONE;
            end
            if (st_q.hold > HOLD_W'(1)) begin
                st_d.hold = st_q.hold - HOLD_W'(1);
            end else if (st_q.hold == HOLD_W'(1)) begin
                st_d.hold = '0;
                st_d.rst  = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            st_q.rst   <= 1'b1;
            st_q.hold  <= HOLD_W'(HOLD_CYCLES);
            st_q.cause <= CAUSE_SUPPLY;
        end else begin
            st_q <= st_d;
        end
    end

    assign rst_active = st_q.rst;
    assign cause      = st_q.cause;

    // R2: a low supply always leads to an active reset on the next edge
    assert_supply_forces_R2: assert property (@(posedge clk) disable iff (!por_n)
        sup_low |=> rst_active);

    // R3: release only on an edge where no cause was present
    assert_release_clean_R3: assert property (@(posedge clk) disable iff (!por_n)
        $fell(st_q.rst) |-> (!$past(sup_low) && !$past(wd_exp)));

    // R9: entering reset always records a cause
    assert_cause_on_entry_R9: assert property (@(posedge clk) disable iff (!por_n)
        $rose(st_q.rst) |-> (st_q.cause != CAUSE_NONE));

    // R10: the watchdog cannot expire while reset is held
    assert_no_expiry_in_reset_R10: assert property (@(posedge clk) disable iff (!por_n)
        st_q.rst |-> !wd_exp);
endmodule

// File: rtl/rst_supervisor.sv
module rst_supervisor #(
    parameter int unsigned HOLD_CYCLES = 250_000,
    parameter int unsigned WD_T1       = 100_000,
    parameter int unsigned WD_T2       = 600_000,
    parameter int unsigned WD_T3       = 1_400_000
) (
    input  logic       clk,
    input  logic       por_n,
    input  logic       supply_low_a,
    input  logic       sda_in,
    input  logic       wd_en,
    input  logic [1:0] wd_sel,
    input  logic       rst_pol_high,
    input  logic       status_clr,
    output logic       rst_oe,
    output logic       rst_lvl,
    output logic [1:0] rst_cause
);
    logic [1:0] sync_out;
    logic       sup_low_s;
    logic       sda_s;
    logic       rst_active;
    logic       wd_arm;
    logic       wd_exp;

    // bit 0: supply flag (resets to "low supply"), bit 1: data line
    rsv_sync2 #(
        .W       (2),
        .RST_VAL (2'b01)
    ) u_sync (
        .clk   (clk),
        .por_n (por_n),
        .din   ({sda_in, supply_low_a}),
        .dout  (sync_out)
    );

    assign sup_low_s = sync_out[0];
    assign sda_s     = sync_out[1];
    assign wd_arm    = wd_en && (wd_sel != 2'd0) && !rst_active;

    rsv_bus_watchdog #(
        .WD_T1 (WD_T1),
        .WD_T2 (WD_T2),
        .WD_T3 (WD_T3)
    ) u_wdog (
        .clk    (clk),
        .por_n  (por_n),
        .sda_s  (sda_s),
        .arm    (wd_arm),
        .sel    (wd_sel),
        .expire (wd_exp)
    );

    rsv_hold_ctrl #(
        .HOLD_CYCLES (HOLD_CYCLES)
    ) u_hold (
        .clk        (clk),
        .por_n      (por_n),
        .sup_low    (sup_low_s),
        .wd_exp     (wd_exp),
        .status_clr (status_clr),
        .rst_active (rst_active),
        .cause      (rst_cause)
    );

    assign rst_oe  = rst_active;
    assign rst_lvl = rst_pol_high;

    // R8: the pin is pulled only while a cause is present or the hold runs
    assert_pull_only_in_reset_R8: assert property (@(posedge clk) disable iff (!por_n)
        (rst_oe && !$past(rst_oe)) |-> ($past(sup_low_s) || $past(wd_exp)));
endmodule

// File: tb/rst_supervisor_tb.sv
module rst_supervisor_tb_top;
    localparam int CLK_P = 10;
    localparam int HOLD  = 40;
    localparam int T1    = 20;
    localparam int T2    = 50;
    localparam int T3    = 100;

    logic       clk = 1'b0;
    logic       por_n = 1'b0;
    logic       supply_low_a = 1'b0;
    logic       sda_in = 1'b0;
    logic       wd_en = 1'b0;
    logic [1:0] wd_sel = 2'd0;
    logic       rst_pol_high = 1'b0;
    logic       status_clr = 1'b0;
    logic       rst_oe;
    logic       rst_lvl;
    logic [1:0] rst_cause;

    int cyc = 0;
    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    typedef struct {
        int         at;
        int         kind;
        logic [1:0] val;
        string      req;
    } exp_t;

    exp_t sb_q[$];

    rst_supervisor #(
        .HOLD_CYCLES (HOLD),
        .WD_T1       (T1),
        .WD_T2       (T2),
        .WD_T3       (T3)
    ) dut_i (
        .clk          (clk),
        .por_n        (por_n),
        .supply_low_a (supply_low_a),
        .sda_in       (sda_in),
        .wd_en        (wd_en),
        .wd_sel       (wd_sel),
        .rst_pol_high (rst_pol_high),
        .status_clr   (status_clr),
        .rst_oe       (rst_oe),
        .rst_lvl      (rst_lvl),
        .rst_cause    (rst_cause)
    );

    always #(CLK_P / 2) clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    // kind 0: rst_oe, 1: rst_lvl, 2: rst_cause
    function automatic void push_exp(int at, int kind, logic [1:0] val, string req);
        exp_t e;
        int   i;
        e.at = at; e.kind = kind; e.val = val; e.req = req;
        i = 0;
        while (i < sb_q.size() && sb_q[i].at <= at) i++;
        sb_q.insert(i, e);
    endfunction

    // monitor: samples a quarter period after each rising edge
    always @(posedge clk) begin
        #(CLK_P / 4);
        while (sb_q.size() > 0 && sb_q[0].at <= cyc) begin
            exp_t       e;
            logic [1:0] act;
            e = sb_q.pop_front();
            case (e.kind)
                0:       act = {1'b0, rst_oe};
                1:       act = {1'b0, rst_lvl};
                default: act = rst_cause;
            endcase
            checks++;
            if (e.at != cyc || act !== e.val) begin
                failures++;
                $display("FAIL %s kind=%0d cycle=%0d/%0d actual=%b expected=%b",
                         e.req, e.kind, cyc, e.at, act, e.val);
            end
        end
    end

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic step_to(int target);
        while (cyc < target) @(negedge clk);
    endtask

    task automatic report();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            report();
            $finish;
        end
    end

    initial begin
        int c;
        int e1;
        step(3);
        // R1: power-on state, then release of the power-on reset
        c = cyc;
        push_exp(c + 1, 0, 2'b01, "R1");
        push_exp(c + 1, 2, 2'b01, "R9");
        push_exp(c + 1, 1, 2'b00, "R8");
        por_n = 1'b1;
        push_exp(c + HOLD + 1, 0, 2'b01, "R1");
        push_exp(c + HOLD + 2, 0, 2'b00, "R1");
        step(HOLD + 5);

        // R8 polarity, R9 clear
        c = cyc;
        rst_pol_high = 1'b1;
        status_clr = 1'b1;
        push_exp(c + 1, 1, 2'b01, "R8");
        push_exp(c + 1, 2, 2'b00, "R9");
        push_exp(c + 1, 0, 2'b00, "R8");
        step(1);
        status_clr = 1'b0;
        step(2);

        // R2 supply dip; R9 clear collides with the new cause
        c = cyc;
        supply_low_a = 1'b1;
        push_exp(c + 2, 0, 2'b00, "R2");
        push_exp(c + 3, 0, 2'b01, "R2");
        push_exp(c + 3, 2, 2'b01, "R9");
        push_exp(c + 12, 0, 2'b01, "R2");
        step(2);
        status_clr = 1'b1;
        step(1);
        status_clr = 1'b0;
        step(12);
        // R3 recovery hold
        c = cyc;
        supply_low_a = 1'b0;
        push_exp(c + HOLD + 1, 0, 2'b01, "R3");
        push_exp(c + HOLD + 2, 0, 2'b00, "R3");
        step(HOLD + 5);

        // R6 disabled watchdog, both ways
        wd_en = 1'b0;
        wd_sel = 2'd1;
        step(150);
        push_exp(cyc + 1, 0, 2'b00, "R6");
        wd_en = 1'b1;
        wd_sel = 2'd0;
        step(150);
        push_exp(cyc + 1, 0, 2'b00, "R6");

        // R5 servicing by rising and falling transitions
        wd_sel = 2'd1;
        for (int k = 0; k < 12; k++) begin
            sda_in = ~sda_in;
            step(10);
        end
        push_exp(cyc + 1, 0, 2'b00, "R5");

        // R4 timeout, R7 hold after it, R10 restart after release
        c = cyc;
        sda_in = ~sda_in;
        e1 = c + 3 + T1;
        push_exp(e1 - 1, 0, 2'b00, "R4");
        push_exp(e1, 0, 2'b01, "R4");
        push_exp(e1, 2, 2'b10, "R9");
        push_exp(e1 + HOLD - 1, 0, 2'b01, "R7");
        push_exp(e1 + HOLD, 0, 2'b00, "R7");
        push_exp(e1 + HOLD + T1 - 1, 0, 2'b00, "R10");
        push_exp(e1 + HOLD + T1, 0, 2'b01, "R10");
        step_to(e1 + HOLD + T1);
        wd_en = 1'b0;
        step(HOLD + 5);

        // R4 second window
        c = cyc;
        wd_en = 1'b1;
        wd_sel = 2'd2;
        sda_in = ~sda_in;
        push_exp(c + 2 + T2, 0, 2'b00, "R4");
        push_exp(c + 3 + T2, 0, 2'b01, "R4");
        step_to(c + 3 + T2);
        wd_en = 1'b0;
        step(HOLD + 5);

        // R4 third window
        c = cyc;
        wd_en = 1'b1;
        wd_sel = 2'd3;
        sda_in = ~sda_in;
        push_exp(c + 2 + T3, 0, 2'b00, "R4");
        push_exp(c + 3 + T3, 0, 2'b01, "R4");
        push_exp(c + 3 + T3, 2, 2'b10, "R9");
        step_to(c + 3 + T3);
        wd_en = 1'b0;
        step(HOLD + 5);

        step(3);
        if (sb_q.size() != 0) begin
            checks++;
            failures++;
            $display("FAIL scoreboard pending actual=%0d expected=0", sb_q.size());
        end
        done = 1'b1;
        report();
        $finish;
    end
endmodule